// File: doc/BRIEF.md
# Single-Bus Memory Read Sequencer

This block is a slice of a processor datapath built around one shared internal bus. It holds a small bank of general registers with a separate capture enable and drive enable for each register. It also holds a memory address register, a memory data register, an operand register Y and a program counter. The counter is stepped by an adder whose first operand comes through a multiplexer: either Y or the constant one.

A control sequencer moves one word from memory into a chosen general register. A start command carries the memory address and the destination index. The sequencer walks a fixed series of clock-edge steps, and at most one source drives the bus in any step:
- the command address goes onto the bus and into the address register;
- a read request goes out and the counter is stepped;
- the sequencer waits for the memory's completion flag;
- the data register goes onto the bus into the destination register.

The memory may take any number of cycles to answer. A single-cycle done pulse marks the end of a transfer. An inspection port lets the general registers be read out.

Top module: `mem_read_seq`

## Requirements
- R1: A start accepted in the idle state places its address into the address register in the next step. `mem_addr_o` shows that address in every cycle in which the read request is high.
- R2: The read request rises in the second cycle after the accepting edge. It stays high until the completion flag is sampled high, so it lasts L+1 cycles when memory answers L cycles after the request rises.
- R3: On the edge where the read request and the completion flag are both high, the data register captures `mem_data_i`. The read request is low in the following cycle.
- R4: After a transfer the destination register holds the memory word. Every other general register is unchanged. A register changes only on an edge where its capture enable is high.
- R5: At most one bus source has its drive enable active in any cycle. In the step where the data register drives the bus, both the destination register and Y capture the word, so after the transfer `y_o` equals the memory word.
- R6: Each transfer adds exactly one to the program counter (`pc_o`). The bus carries the counter value and the adder's first operand is the constant one.
- R7: `done_o` is high for exactly one cycle, L+4 cycles after the accepting edge.
- R8: A start raised while a transfer is in progress is ignored. No second transfer begins, no second register is written and the counter is not stepped again.
- R9: A synchronous reset (`rst` high at a rising edge) returns the sequencer to idle and drops the read request and done. It clears all general registers, Y and the counter to zero. A start after reset runs normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a read transfer (sampled in idle only) |
| start_addr_i | input | AW | Memory address for the transfer |
| start_dst_i | input | log2(NREG) | Index of the destination general register |
| mem_addr_o | output | AW | Address register contents, presented to memory |
| mem_rd_o | output | 1 | Read request to memory |
| mem_data_i | input | DW | Read data from memory |
| mem_mfc_i | input | 1 | Memory completion flag |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| obs_sel_i | input | log2(NREG) | Inspection port register index |
| obs_gpr_o | output | DW | Contents of the selected general register |
| y_o | output | DW | Contents of the Y operand register |
| pc_o | output | DW | Program counter |

## Verification
The assertions assume the memory raises its completion flag only while the read request is high. They also assume the read data is valid whenever that flag is high. The start fields need only be valid in the cycle a start is accepted. The bench memory model derives its flag from the read request and a per-transfer latency counter of 0 to 7 cycles. It computes the read data from the presented address, so it never answers without a request. Stray starts are injected only into a transfer that is already running.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ADDR  = 3'd1,
        S_REQ   = 3'd2,
        S_WAIT  = 3'd3,
        S_MOVE  = 3'd4,
        S_DONE  = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic cmd_oe;     // command address drives the bus
        logic pc_oe;      // program counter drives the bus
        logic mdr_oe;     // data register drives the bus
        logic mar_ie;     // address register captures the bus
        logic y_ie;       // Y captures the bus
        logic pc_ie;      // program counter captures the adder result
        logic gpr_ie;     // destination register captures the bus
        logic alu_use_y;  // adder first operand: 1 = Y, 0 = constant one
        logic mdr_ld;     // data register captures memory data
        logic mem_rd;     // read request
        logic done;       // transfer complete
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input seq_state_e s, input logic mfc);
        ctrl_t c;
        c = '0;
        case (s)
            S_ADDR: begin
                c.cmd_oe = 1'b1;
                c.mar_ie = 1'b1;
            end
            S_REQ: begin
                c.mem_rd = 1'b1;
                c.pc_oe  = 1'b1;
                c.pc_ie  = 1'b1;
                c.mdr_ld = mfc;
            end
            S_WAIT: begin
                c.mem_rd = 1'b1;
                c.mdr_ld = mfc;
            end
            S_MOVE: begin
                c.mdr_oe = 1'b1;
                c.gpr_ie = 1'b1;
                c.y_ie   = 1'b1;
            end
            S_DONE: c.done = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic seq_state_e next_state(input seq_state_e s, input logic start,
                                              input logic mfc);
        seq_state_e n;
        case (s)
            S_IDLE:  n = start ? S_ADDR : S_IDLE;
            S_ADDR:  n = S_REQ;
            S_REQ,
            S_WAIT:  n = mfc ? S_MOVE : S_WAIT;
            S_MOVE:  n = S_DONE;
            default: n = S_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
    import sbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       mfc_i,
    output seq_state_e state_o,
    output ctrl_t      ctrl_o,
    output logic       accept_o
);

    seq_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= next_state(state_q, start_i, mfc_i);
    end

    assign state_o  = state_q;
    assign ctrl_o   = decode_ctrl(state_q, mfc_i);
    assign accept_o = (state_q == S_IDLE) && start_i;

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE && start_i) |=> (state_q != S_ADDR)); // R8

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT && !mfc_i) |=> (state_q == S_WAIT)); // R2

    AST_ADDR_THEN_REQ: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_ADDR) |=> (state_q == S_REQ)); // R2

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
    parameter int  DW   = 16,
    parameter int  NREG = 8,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   bus_i,
    input  logic [NREG-1:0] ie_i,
    input  logic [NREG-1:0] oe_i,
    output logic [DW-1:0]   drv_o,
    input  logic [IDXW-1:0] obs_sel_i,
    output logic [DW-1:0]   obs_q_o
);

    logic [DW-1:0] q_r    [NREG];
    logic [DW-1:0] masked [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)         q_r[g] <= '0;
            else if (ie_i[g]) q_r[g] <= bus_i;
        end

        assign masked[g] = oe_i[g] ? q_r[g] : '0;

        AST_GPR_HOLD: assert property (@(posedge clk) disable iff (rst)
            !ie_i[g] |=> $stable(q_r[g])); // R4

        AST_GPR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            ie_i[g] |=> (q_r[g] == $past(bus_i))); // R4
    end

    always_comb begin
        drv_o = '0;
        for (int i = 0; i < NREG; i++) drv_o = drv_o | masked[i];
    end

    assign obs_q_o = q_r[obs_sel_i];

endmodule

// File: rtl/alu_pc.sv
module alu_pc #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] bus_i,
    input  logic          y_ie_i,
    input  logic          pc_ie_i,
    input  logic          use_y_i,
    output logic [DW-1:0] y_o,
    output logic [DW-1:0] pc_o
);

    logic [DW-1:0] y_q, pc_q, op_a, sum;

    always_ff @(posedge clk) begin
        if (rst)         y_q <= '0;
        else if (y_ie_i) y_q <= bus_i;
    end

    assign op_a = use_y_i ? y_q : DW'(1);
    assign sum  = op_a + bus_i;

    always_ff @(posedge clk) begin
        if (rst)          pc_q <= '0;
        else if (pc_ie_i) pc_q <= sum;
    end

    assign y_o  = y_q;
    assign pc_o = pc_q;

    AST_Y_HOLD: assert property (@(posedge clk) disable iff (rst)
        !y_ie_i |=> $stable(y_q)); // R5

endmodule

// File: rtl/mem_read_seq.sv
module mem_read_seq
    import sbus_pkg::*;
#(
    parameter int  DW   = 16,
    parameter int  AW   = 8,
    parameter int  NREG = 8,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [AW-1:0]   start_addr_i,
    input  logic [IDXW-1:0] start_dst_i,
    output logic [AW-1:0]   mem_addr_o,
    output logic            mem_rd_o,
    input  logic [DW-1:0]   mem_data_i,
    input  logic            mem_mfc_i,
    output logic            done_o,
    input  logic [IDXW-1:0] obs_sel_i,
    output logic [DW-1:0]   obs_gpr_o,
    output logic [DW-1:0]   y_o,
    output logic [DW-1:0]   pc_o
);

    seq_state_e      state;
    ctrl_t           ctrl;
    logic            accept;
    logic [AW-1:0]   cmd_addr_q, mar_q;
    logic [IDXW-1:0] cmd_dst_q;
    logic [DW-1:0]   mdr_q, bus, gpr_drv;
    logic [NREG-1:0] gpr_ie, gpr_oe;

    seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .mfc_i    (mem_mfc_i),
        .state_o  (state),
        .ctrl_o   (ctrl),
        .accept_o (accept)
    );

    // Command fields are held for the whole transfer.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_addr_q <= '0;
            cmd_dst_q  <= '0;
        end else if (accept) begin
            cmd_addr_q <= start_addr_i;
            cmd_dst_q  <= start_dst_i;
        end
    end

    assign gpr_ie = ctrl.gpr_ie ? (NREG'(1) << cmd_dst_q) : '0;
    assign gpr_oe = '0;  // no register-to-register move in the read sequence

    // Shared bus: OR of gated sources, at most one gate open per cycle.
    assign bus = (ctrl.cmd_oe ? DW'(cmd_addr_q) : '0)
               | (ctrl.pc_oe  ? pc_o            : '0)
               | (ctrl.mdr_oe ? mdr_q           : '0)
               | gpr_drv;

    always_ff @(posedge clk) begin
        if (rst)              mar_q <= '0;
        else if (ctrl.mar_ie) mar_q <= bus[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)              mdr_q <= '0;
        else if (ctrl.mdr_ld) mdr_q <= mem_data_i;
    end

    gpr_bank #(.DW(DW), .NREG(NREG)) u_gpr (
        .clk       (clk),
        .rst       (rst),
        .bus_i     (bus),
        .ie_i      (gpr_ie),
        .oe_i      (gpr_oe),
        .drv_o     (gpr_drv),
        .obs_sel_i (obs_sel_i),
        .obs_q_o   (obs_gpr_o)
    );

    alu_pc #(.DW(DW)) u_alu (
        .clk     (clk),
        .rst     (rst),
        .bus_i   (bus),
        .y_ie_i  (ctrl.y_ie),
        .pc_ie_i (ctrl.pc_ie),
        .use_y_i (ctrl.alu_use_y),
        .y_o     (y_o),
        .pc_o    (pc_o)
    );

    assign mem_addr_o = mar_q;
    assign mem_rd_o   = ctrl.mem_rd;
    assign done_o     = ctrl.done;

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl.cmd_oe, ctrl.pc_oe, ctrl.mdr_oe, gpr_oe})); // R5

    AST_MAR_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
        (state == S_ADDR) |=> (mem_addr_o == $past(cmd_addr_q))); // R1

    AST_MDR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && mem_mfc_i) |=> (mdr_q == $past(mem_data_i))); // R3

    AST_RD_DROP: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && mem_mfc_i) |=> !mem_rd_o); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pc_ie && ctrl.pc_oe && !ctrl.alu_use_y) |=> (pc_o == $past(pc_o) + DW'(1))); // R6

    AST_MOVE_AFTER_MFC: assert property (@(posedge clk) disable iff (rst)
        ctrl.mdr_oe |-> (state == S_MOVE && $past(mem_rd_o && mem_mfc_i))); // R3

endmodule

// File: tb/test_mem_read_seq.sv
`timescale 1ns/1ps
module test_mem_read_seq;

    localparam int DW = 16;
    localparam int AW = 8;
    localparam int NREG = 8;

    // Vector layout: {address[15:8], destination[7:4], latency[3:0]}
    localparam logic [15:0] VEC [0:7] = '{
        16'h3210, 16'hA721, 16'h0532, 16'hFF43,
        16'h0054, 16'h8165, 16'h5C76, 16'h3207
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [2:0] st_dst = '0;
    logic [AW-1:0] mem_addr;
    logic mem_rd, mfc, done;
    logic [DW-1:0] mem_data, obs_q, y_q, pc_q;
    logic [2:0] obs_sel = '0;
    int lat_cfg = 0;
    int wcnt = 0;
    int checks = 0;
    int errors = 0;
    logic [DW-1:0] shadow [NREG];

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return {a, ~a} ^ 16'h3C5A;
    endfunction

    always @(posedge clk) wcnt <= mem_rd ? wcnt + 1 : 0;
    assign mfc      = mem_rd && (wcnt >= lat_cfg);
    assign mem_data = memf(mem_addr);

    mem_read_seq #(.DW(DW), .AW(AW), .NREG(NREG)) i_mem_read_seq (
        .clk(clk), .rst(rst), .start_i(start), .start_addr_i(st_addr),
        .start_dst_i(st_dst), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
        .mem_data_i(mem_data), .mem_mfc_i(mfc), .done_o(done),
        .obs_sel_i(obs_sel), .obs_gpr_o(obs_q), .y_o(y_q), .pc_o(pc_q)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_bank(input string tag);
        int bad = 0;
        for (int i = 0; i < NREG; i++) begin
            obs_sel = 3'(i);
            #1;
            if (obs_q !== shadow[i]) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic xfer(input logic [AW-1:0] a, input logic [2:0] d, input int lat,
                        input bit poke);
        int cyc = 0;
        int rdc = 0;
        int first_rd = -1;
        bit prev_hit = 0;
        bit addr_ok = 1;
        bit drop_ok = 1;
        logic [DW-1:0] pc0;
        @(negedge clk);
        lat_cfg = lat; st_addr = a; st_dst = d; start = 1'b1; pc0 = pc_q;
        do begin
            @(negedge clk);
            cyc++;
            start = poke && (cyc == 3);
            if (poke && cyc == 3) begin st_addr = ~a; st_dst = d + 3'd1; end
            if (prev_hit && mem_rd) drop_ok = 0;
            if (mem_rd) begin
                rdc++;
                if (first_rd < 0) first_rd = cyc;
                if (mem_addr !== a) addr_ok = 0;
            end
            prev_hit = mem_rd && mfc;
        end while (!done && cyc < 60);
        chk(addr_ok, "R1 address shown during read", {24'h0, mem_addr}, {24'h0, a});
        chk(first_rd == 2, "R2 read request start cycle", first_rd, 2);
        chk(rdc == lat + 1, "R2 read request length", rdc, lat + 1);
        chk(drop_ok, "R3 read dropped after completion", drop_ok, 1);
        chk(cyc == lat + 4, "R7 done latency", cyc, lat + 4);
        shadow[d] = memf(a);
        check_bank("R4 destination written, others unchanged");
        chk(y_q === memf(a), "R5 Y captured with destination", y_q, memf(a));
        chk(pc_q === pc0 + 16'd1, "R6 counter stepped once", pc_q, pc0 + 16'd1);
        @(negedge clk);
        chk(done === 1'b0, "R7 done is a single pulse", done, 0);
        if (poke) begin
            int extra = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (mem_rd || done) extra++;
            end
            chk(extra == 0, "R8 no second transfer after busy start", extra, 0);
            chk(pc_q === pc0 + 16'd1, "R8 counter not stepped again", pc_q, pc0 + 16'd1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_rd && !done, "R9 reset outputs idle", {mem_rd, done}, 0);
        chk(pc_q === '0 && y_q === '0, "R9 reset counter and Y", pc_q, 0);
        check_bank("R9 reset clears registers");

        for (int v = 0; v < 8; v++)
            xfer(VEC[v][15:8], VEC[v][6:4], int'(VEC[v][3:0]), 1'b0);

        xfer(8'h44, 3'd2, 5, 1'b1);   // R8 stray start during wait

        // R9 reset in the middle of a transfer
        @(negedge clk);
        lat_cfg = 7; st_addr = 8'h99; st_dst = 3'd6; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!mem_rd && !done, "R9 mid-transfer reset drops request", {mem_rd, done}, 0);
        chk(pc_q === '0, "R9 mid-transfer reset clears counter", pc_q, 0);
        for (int i = 0; i < NREG; i++) shadow[i] = '0;
        check_bank("R9 mid-transfer reset clears registers");
        xfer(8'h10, 3'd5, 0, 1'b0);   // R9 runs normally after reset

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule